// File: doc/BRIEF.md
# Three-Slot Asymmetric Decode Steering

This block sits between an in-order instruction queue and three decode slots of unequal ability. Slot 0 is a full decoder that accepts any instruction; slots 1 and 2 are simple decoders that accept only single-micro-op instructions. Each cycle the queue shows its oldest three entries. Each entry carries a valid bit, a micro-op count, a microcoded flag and a hold length. The block decides how many of them decode this cycle. It fills the slots strictly in program order, with slot 0 always first, so the best case per cycle is one wide instruction followed by two single-micro-op instructions.

A microcoded instruction enters slot 0 alone and then keeps that slot for a number of cycles taken from its own hold field. Slots 1 and 2 stay empty for that whole time. A low downstream ready freezes everything: nothing is popped, no slot is reported valid, and any microcode hold in progress stops counting down.

The pop count is combinational so the queue can advance at the same clock edge. The slot valids, the per-slot micro-op counts and the hold flag are registered.

Top module: `decode_steer`

## Requirements
- R1: After reset, `slotValid` is 000, `slotUops` is zero, `slot0Mcode` is 0 and `holdActive` is 0.
- R2: An instruction whose micro-op count is 1 and whose microcoded flag is clear may decode in any slot. Three such valid entries pop 3 and give `slotValid` 111.
- R3: An instruction with a micro-op count other than 1 decodes only in slot 0. Entry 0 with count 4 followed by two single entries pops 3. A non-single entry at queue position 1 or 2 is not taken that cycle.
- R4: Slots 1 and 2 are filled only when slot 0 is filled in the same cycle, and slot 2 only when slot 1 is filled. If entry 0 is invalid, the pop count is 0 whatever the other valids are.
- R5: Assignment is in program order. Once an entry is refused, no later entry decodes that cycle.
- R6: A microcoded entry decodes only in slot 0, and in its start cycle nothing else is popped. `slot0Mcode` is 1 in the cycle after it is popped.
- R7: A microcoded entry holds slot 0 for H cycles in total, counting its start cycle. H is its hold field, 4 bits wide at `inHold[3:0]`, and values below 2 count as 2. During the H-1 following ready cycles `holdActive` is 1 and the pop count is 0.
- R8: While `downReady` is 0, the pop count is 0, `slotValid` becomes 000 at the next edge, and a hold in progress does not count down.
- R9: `slotValid` and `slotUops` are registered. They show the entries popped in the previous cycle. Slot k's count is at `slotUops[3k+2:3k]`, and an unfilled slot shows count 0.
- R10: The number of ones in `slotValid` always equals the pop count of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 3 | Valid bit of the queue's three oldest entries, bit 0 oldest |
| inUops | input | 9 | Micro-op count per entry, 3 bits each, entry k at [3k+2:3k] |
| inMcode | input | 3 | Microcoded flag per entry |
| inHold | input | 12 | Microcode hold length per entry, 4 bits each |
| downReady | input | 1 | Downstream ready; low stalls all slots |
| popCnt | output | 2 | Entries consumed from the queue front this cycle (combinational) |
| slotValid | output | 3 | Registered per-slot valid |
| slotUops | output | 9 | Registered per-slot micro-op count |
| slot0Mcode | output | 1 | Registered: slot 0 started a microcoded instruction |
| holdActive | output | 1 | Slot 0 is still held by a microcoded instruction |

## Verification
Two things can arrive in the same cycle: a downstream stall and a microcode hold that is counting down. Both should block popping, but only the ready cycles may shorten the hold. The bench starts a hold of 3 and stalls for three cycles right after the start cycle. It then requires exactly two further cycles with no pop before a full pattern of three pops is accepted. A stall that wrongly counted down, or a hold that wrongly ignored the stall, shows up as an early or late pop.

// File: rtl/decode_steer_pkg.sv
package decode_steer_pkg;
  localparam int unsigned STEER_SLOTS = 3;

  // strobes from the steering control to the output datapath
  typedef struct packed {
    logic [STEER_SLOTS-1:0] take;
    logic                   mcStart;
  } steer_strobe_t;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import decode_steer_pkg::*;
#(
  parameter int unsigned UOPW     = 3,
  parameter int unsigned HOLDW    = 4,
  parameter int unsigned HOLD_MIN = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [STEER_SLOTS-1:0]       inValid,
  input  logic [STEER_SLOTS*UOPW-1:0]  inUops,
  input  logic [STEER_SLOTS-1:0]       inMcode,
  input  logic [HOLDW-1:0]             hold0,
  input  logic                         downReady,
  output steer_strobe_t                strobe,
  output logic [$clog2(STEER_SLOTS+1)-1:0] popCnt,
  output logic                         holdActive
);
  localparam int unsigned PCW = $clog2(STEER_SLOTS+1);
  localparam logic [HOLDW-1:0] HOLD_FLOOR = HOLDW'(HOLD_MIN);

  logic [HOLDW-1:0]       holdCnt;
  logic [HOLDW-1:0]       holdLen;
  logic [STEER_SLOTS-1:0] single;
  logic [STEER_SLOTS-1:0] take;
  logic                   busy;

  assign busy = (holdCnt != '0);

  // slot 0 accepts anything when not held and not stalled
  assign take[0] = downReady && !busy && inValid[0];

  generate
    for (genvar k = 0; k < STEER_SLOTS; k++) begin : g_single
      assign single[k] = (inUops[k*UOPW +: UOPW] == UOPW'(1)) && !inMcode[k];
    end
    for (genvar k = 1; k < STEER_SLOTS; k++) begin : g_chain
      // in-order chain: a simple slot fills only behind its neighbour
      assign take[k] = take[k-1] && !inMcode[0] && inValid[k] && single[k];
    end
  endgenerate

  always_comb begin
    popCnt = '0;
    for (int k = 0; k < STEER_SLOTS; k++) begin
      popCnt = popCnt + PCW'(take[k]);
    end
  end

  assign holdLen = (hold0 < HOLD_FLOOR) ? HOLD_FLOOR : hold0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (downReady) begin
      if (busy) begin
        holdCnt <= holdCnt - 1'b1;
      end else if (take[0] && inMcode[0]) begin
        holdCnt <= holdLen - 1'b1;
      end
    end
  end

  assign strobe.take    = take;
  assign strobe.mcStart = take[0] && inMcode[0];
  assign holdActive     = busy;
endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import decode_steer_pkg::*;
#(
  parameter int unsigned UOPW = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  steer_strobe_t               strobe,
  input  logic [STEER_SLOTS*UOPW-1:0] inUops,
  output logic [STEER_SLOTS-1:0]      slotValid,
  output logic [STEER_SLOTS*UOPW-1:0] slotUops,
  output logic                        slot0Mcode
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid  <= '0;
      slotMcodeReset();
    end else begin
      slotValid  <= strobe.take;
      slot0Mcode <= strobe.mcStart;
    end
  end

  task automatic slotMcodeReset();
    slot0Mcode <= 1'b0;
  endtask

  generate
    for (genvar k = 0; k < STEER_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotUops[k*UOPW +: UOPW] <= '0;
        end else begin
          slotUops[k*UOPW +: UOPW] <= strobe.take[k] ? inUops[k*UOPW +: UOPW] : '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import decode_steer_pkg::*;
#(
  parameter int unsigned UOPW     = 3,
  parameter int unsigned HOLDW    = 4,
  parameter int unsigned HOLD_MIN = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [STEER_SLOTS-1:0]       inValid,
  input  logic [STEER_SLOTS*UOPW-1:0]  inUops,
  input  logic [STEER_SLOTS-1:0]       inMcode,
  input  logic [STEER_SLOTS*HOLDW-1:0] inHold,
  input  logic                         downReady,
  output logic [$clog2(STEER_SLOTS+1)-1:0] popCnt,
  output logic [STEER_SLOTS-1:0]       slotValid,
  output logic [STEER_SLOTS*UOPW-1:0]  slotUops,
  output logic                         slot0Mcode,
  output logic                         holdActive
);
  steer_strobe_t strobe;

  steer_ctrl #(.UOPW(UOPW), .HOLDW(HOLDW), .HOLD_MIN(HOLD_MIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inUops(inUops),
    .inMcode(inMcode), .hold0(inHold[HOLDW-1:0]), .downReady(downReady),
    .strobe(strobe), .popCnt(popCnt), .holdActive(holdActive)
  );

  steer_dp #(.UOPW(UOPW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inUops(inUops),
    .slotValid(slotValid), .slotUops(slotUops), .slot0Mcode(slot0Mcode)
  );
endmodule

// File: rtl/steer_checker.sv
module steer_checker
  import decode_steer_pkg::*;
#(
  parameter int unsigned UOPW = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         downReady,
  input logic [$clog2(STEER_SLOTS+1)-1:0] popCnt,
  input logic [STEER_SLOTS-1:0]       slotValid,
  input logic [STEER_SLOTS*UOPW-1:0]  slotUops,
  input logic                         slot0Mcode,
  input logic                         holdActive
);
  AST_SLOT1_NEEDS_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    slotValid[1] |-> slotValid[0]); // R4
  AST_SLOT2_NEEDS_SLOT1: assert property (@(posedge clk) disable iff (!rstN)
    slotValid[2] |-> slotValid[1]); // R5
  AST_SIMPLE_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    slotValid[1] |-> (slotUops[2*UOPW-1:UOPW] == UOPW'(1))); // R3
  AST_MCODE_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    slot0Mcode |-> (slotValid == 3'b001)); // R6
  AST_HOLD_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> (popCnt == '0)); // R7
  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    !downReady |-> (popCnt == '0)); // R8
  AST_STALL_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!downReady && holdActive) |=> holdActive); // R8
  AST_POP_MATCHES_SLOTS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(slotValid) == int'($past(popCnt)))); // R10
endmodule

bind decode_steer steer_checker #(.UOPW(UOPW)) u_checker (
  .clk(clk), .rstN(rstN), .downReady(downReady), .popCnt(popCnt),
  .slotValid(slotValid), .slotUops(slotUops), .slot0Mcode(slot0Mcode),
  .holdActive(holdActive)
);

// File: tb/decode_steer_bench.sv
module decode_steer_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] inValid;
  logic [8:0] inUops;
  logic [2:0] inMcode;
  logic [11:0] inHold;
  logic       downReady;
  logic [1:0] popCnt;
  logic [2:0] slotValid;
  logic [8:0] slotUops;
  logic       slot0Mcode;
  logic       holdActive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  decode_steer u_decode_steer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inUops(inUops),
    .inMcode(inMcode), .inHold(inHold), .downReady(downReady),
    .popCnt(popCnt), .slotValid(slotValid), .slotUops(slotUops),
    .slot0Mcode(slot0Mcode), .holdActive(holdActive)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle: inputs after the falling edge, pop checked before the
  // rising edge, registered slots checked just after it
  task automatic step(input string req, input logic [2:0] v, input logic [2:0] mc,
                      input int u0, input int u1, input int u2, input int h,
                      input logic rdy, input int expPop, input int expValid);
    @(negedge clk);
    inValid = v; inMcode = mc; downReady = rdy;
    inUops = {3'(u2), 3'(u1), 3'(u0)};
    inHold = {4'd0, 4'd0, 4'(h)};
    #1;
    check({req, " pop"}, int'(popCnt), expPop);
    @(posedge clk); #1;
    check({req, " slotValid"}, int'(slotValid), expValid);
  endtask

  task automatic t_reset();
    check("R1 slotValid", int'(slotValid), 0);
    check("R1 slotUops", int'(slotUops), 0);
    check("R1 slot0Mcode", int'(slot0Mcode), 0);
    check("R1 holdActive", int'(holdActive), 0);
  endtask

  task automatic t_singles();
    step("R2 three singles", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 3, 3'b111);
    check("R9 slotUops singles", int'(slotUops), 9'b001_001_001);
  endtask

  task automatic t_wide_first();
    step("R3 4-1-1", 3'b111, 3'b000, 4, 1, 1, 0, 1'b1, 3, 3'b111);
    check("R9 slot0 uops", int'(slotUops[2:0]), 4);
    step("R3 wide at pos1", 3'b111, 3'b000, 1, 2, 1, 0, 1'b1, 1, 3'b001);
    check("R9 unfilled slot zero", int'(slotUops[8:3]), 0);
    step("R3 wide at pos2", 3'b111, 3'b000, 1, 1, 3, 0, 1'b1, 2, 3'b011);
  endtask

  task automatic t_gap();
    step("R4 entry0 invalid", 3'b110, 3'b000, 1, 1, 1, 0, 1'b1, 0, 3'b000);
    step("R4 two valid", 3'b011, 3'b000, 2, 1, 1, 0, 1'b1, 2, 3'b011);
  endtask

  task automatic t_order();
    step("R5 refused blocks later", 3'b111, 3'b000, 1, 3, 1, 0, 1'b1, 1, 3'b001);
  endtask

  task automatic t_mcode();
    step("R6 mcode at pos1", 3'b111, 3'b010, 1, 1, 1, 0, 1'b1, 1, 3'b001);
    step("R6 mcode start", 3'b111, 3'b001, 1, 1, 1, 5, 1'b1, 1, 3'b001);
    check("R6 slot0Mcode", int'(slot0Mcode), 1);
    check("R7 holdActive set", int'(holdActive), 1);
    for (int c = 0; c < 4; c++) begin
      step("R7 held", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 0, 3'b000);
    end
    check("R7 hold ended", int'(holdActive), 0);
    step("R7 after hold", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 3, 3'b111);
  endtask

  task automatic t_clamp();
    step("R7 hold 0 start", 3'b001, 3'b001, 1, 0, 0, 0, 1'b1, 1, 3'b001);
    step("R7 clamp held", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 0, 3'b000);
    step("R7 clamp free", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 3, 3'b111);
  endtask

  task automatic t_stall();
    step("R8 stall", 3'b111, 3'b000, 1, 1, 1, 0, 1'b0, 0, 3'b000);
    step("R8 mcode hold 3", 3'b111, 3'b001, 1, 1, 1, 3, 1'b1, 1, 3'b001);
    for (int c = 0; c < 3; c++) begin
      step("R8 stall in hold", 3'b111, 3'b000, 1, 1, 1, 0, 1'b0, 0, 3'b000);
      check("R8 hold frozen", int'(holdActive), 1);
    end
    step("R8 hold left 2", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 0, 3'b000);
    step("R8 hold left 1", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 0, 3'b000);
    step("R10 resumes", 3'b111, 3'b000, 1, 1, 1, 0, 1'b1, 3, 3'b111);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = '0; inUops = '0; inMcode = '0; inHold = '0; downReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    t_reset();
    t_singles();
    t_wide_first();
    t_gap();
    t_order();
    t_mcode();
    t_clamp();
    t_stall();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule